// File: doc/BRIEF.md
# Incremental Encoder Position Decoder

This block turns the two phase signals of an incremental shaft encoder into a signed position count at four counts per encoder line. Every accepted edge on either phase moves the count by one, in a direction given by which phase leads. A step in which both phases change at once cannot be resolved. The block flags such a step as an error and leaves the count as it was.

Three event inputs act alongside the count. An index pulse, once per mechanical turn, advances or retreats a turn counter according to the current direction of travel. A home pulse reloads the position with a value supplied by the host. A trigger pulse copies the position and the turn count into hold registers. It also records how far the position has moved since the previous trigger, so a trigger at a fixed rate gives a speed value. All five encoder-side inputs are asynchronous and pass through two-flop synchronizers before any edge is detected.

Top module: `qdec_top`

## Requirements
- R1: With phases written as {A,B}, the up sequence is 00→10→11→01→00. Each single-phase transition along it adds one to `position` and sets `dir_up` to 1.
- R2: Each transition along the reverse sequence (00→01→11→10→00) subtracts one from `position` and sets `dir_up` to 0.
- R3: A transition in which both phases change between two synchronized samples leaves `position` and `dir_up` unchanged and sets `err_illegal`. The flag stays set until `err_clr` is high at a clock edge with no new illegal step.
- R4: A rising edge on `enc_index` adds one to `rev_count` when the direction is up and subtracts one when it is down. The direction used is the one set by a step in the same cycle, or otherwise the stored `dir_up`.
- R5: A rising edge on `enc_home` loads `position` with `home_value`. This load takes precedence over a phase step in the same cycle.
- R6: A rising edge on `enc_trig` copies `position` into `hold_pos` and `rev_count` into `hold_rev`. It also copies into `hold_delta` the difference between that position and the position latched by the previous trigger. The reference for the first trigger after reset is zero.
- R7: After reset, `position`, `rev_count`, all hold outputs and `err_illegal` are zero and `dir_up` is 1.
- R8: A change on an input is reflected at the outputs after the third rising clock edge that follows it, and not earlier.
- R9: An event input held high acts only once. Only its rising edge counts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enc_a | input | 1 | Encoder phase A, asynchronous |
| enc_b | input | 1 | Encoder phase B, asynchronous |
| enc_index | input | 1 | Once-per-turn index pulse, asynchronous |
| enc_home | input | 1 | Home reload pulse, asynchronous |
| enc_trig | input | 1 | Capture trigger, asynchronous |
| home_value | input | POS_W | Value loaded into position on home |
| err_clr | input | 1 | Clears the illegal-step flag |
| position | output | POS_W | Signed position count |
| rev_count | output | REV_W | Signed turn count |
| dir_up | output | 1 | Direction of the last valid step |
| err_illegal | output | 1 | Sticky illegal-step flag |
| hold_pos | output | POS_W | Position captured at last trigger |
| hold_rev | output | REV_W | Turn count captured at last trigger |
| hold_delta | output | POS_W | Position change between last two triggers |

## Verification
A wrong stored phase sample or direction shows up at the next step. The position moves the wrong way or by the wrong amount three edges after that step, and a misread step sets the error flag. A wrong direction register is also visible at the next index pulse, which moves `rev_count` the wrong way. A corrupted trigger reference stays hidden until the next trigger, where it appears in `hold_delta`. The bench therefore triggers twice with known motion in between.

// File: rtl/qdec_pkg.sv
// Shared types for the encoder decoder.
// Assumes: nothing beyond IEEE 1800-2017.
package qdec_pkg;
    // Outcome of comparing two successive phase samples
    typedef enum logic [1:0] {
        STEP_NONE = 2'd0,
        STEP_UP   = 2'd1,
        STEP_DN   = 2'd2,
        STEP_BAD  = 2'd3
    } step_e;
endpackage

// File: rtl/qdec_sync.sv
// Two-flop synchronizer bank with one extra stage that holds the previous
// synchronized sample, so downstream logic can see edges.
// Assumes: inputs are asynchronous single-bit levels; reset value is 0.
module qdec_sync #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] d_async,
    output logic [N-1:0] lvl,
    output logic [N-1:0] prv
);
    genvar g;
    generate
        for (g = 0; g < N; g++) begin : g_bit
            logic m1, m2, m3;
            // per-bit metastability chain plus history stage
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    m1 <= 1'b0;
                    m2 <= 1'b0;
                    m3 <= 1'b0;
                end else begin
                    m1 <= d_async[g];
                    m2 <= m1;
                    m3 <= m2;
                end
            end
            assign lvl[g] = m2;
            assign prv[g] = m3;
        end
    endgenerate
endmodule

// File: rtl/qdec_step.sv
// Classifies the change between two successive {A,B} samples.
// Assumes: samples come from the same synchronizer bank one cycle apart.
module qdec_step
    import qdec_pkg::*;
(
    input  logic [1:0] ab_now,
    input  logic [1:0] ab_old,
    output step_e      step
);
    // Gray-code comparison: forward sequence 00,10,11,01
    always_comb begin
        step = STEP_NONE;
        unique case ({ab_old, ab_now})
            4'b00_10, 4'b10_11, 4'b11_01, 4'b01_00: step = STEP_UP;
            4'b00_01, 4'b01_11, 4'b11_10, 4'b10_00: step = STEP_DN;
            4'b00_11, 4'b11_00, 4'b10_01, 4'b01_10: step = STEP_BAD;
            default:                                step = STEP_NONE;
        endcase
    end
endmodule

// File: rtl/qdec_count.sv
// Position counter, direction, illegal-step flag and turn counter.
// Assumes: step, index_rise and home_rise are single-cycle synchronous.
module qdec_count
    import qdec_pkg::*;
#(
    parameter int POS_W = 32,
    parameter int REV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  step_e            step,
    input  logic             index_rise,
    input  logic             home_rise,
    input  logic [POS_W-1:0] home_value,
    input  logic             err_clr,
    output logic [POS_W-1:0] pos_q,
    output logic [REV_W-1:0] rev_q,
    output logic             dir_q,
    output logic             err_q
);
    logic dir_eff;

    // direction in force this cycle: a fresh step wins over the stored one
    always_comb begin
        dir_eff = dir_q;
        if (step == STEP_UP) dir_eff = 1'b1;
        if (step == STEP_DN) dir_eff = 1'b0;
    end

    // position: home reload beats counting
    always_ff @(posedge clk) begin
        if (!rst_n)                 pos_q <= '0;
        else if (home_rise)         pos_q <= home_value;
        else if (step == STEP_UP)   pos_q <= pos_q + 1'b1;
        else if (step == STEP_DN)   pos_q <= pos_q - 1'b1;
    end

    // stored direction
    always_ff @(posedge clk) begin
        if (!rst_n) dir_q <= 1'b1;
        else        dir_q <= dir_eff;
    end

    // sticky illegal-step flag, set wins over clear
    always_ff @(posedge clk) begin
        if (!rst_n)                 err_q <= 1'b0;
        else if (step == STEP_BAD)  err_q <= 1'b1;
        else if (err_clr)           err_q <= 1'b0;
    end

    // turn counter on index edge
    always_ff @(posedge clk) begin
        if (!rst_n)          rev_q <= '0;
        else if (index_rise) rev_q <= dir_eff ? rev_q + 1'b1 : rev_q - 1'b1;
    end

    assert_bad_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (step == STEP_BAD && !home_rise) |=> (pos_q == $past(pos_q) && err_q));
    assert_up_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (step == STEP_UP && !home_rise) |=> (pos_q == $past(pos_q) + 1'b1 && dir_q));
    assert_dn_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (step == STEP_DN && !home_rise) |=> (pos_q == $past(pos_q) - 1'b1 && !dir_q));
    assert_home_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
        home_rise |=> pos_q == $past(home_value));
    assert_rev_one_R4: assert property (@(posedge clk) disable iff (!rst_n)
        index_rise |=> (rev_q == $past(rev_q) + 1'b1 || rev_q == $past(rev_q) - 1'b1));
    assert_rev_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !index_rise |=> $stable(rev_q));
endmodule

// File: rtl/qdec_capture.sv
// Trigger capture: latches position, turn count and the position change
// since the previous trigger.
// Assumes: trig_rise is a single-cycle pulse; pos/rev are register outputs.
module qdec_capture #(
    parameter int POS_W = 32,
    parameter int REV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             trig_rise,
    input  logic [POS_W-1:0] pos,
    input  logic [REV_W-1:0] rev,
    output logic [POS_W-1:0] hold_pos,
    output logic [REV_W-1:0] hold_rev,
    output logic [POS_W-1:0] hold_delta
);
    logic [POS_W-1:0] ref_pos;

    // snapshot registers and reference position for the next difference
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_pos   <= '0;
            hold_rev   <= '0;
            hold_delta <= '0;
            ref_pos    <= '0;
        end else if (trig_rise) begin
            hold_pos   <= pos;
            hold_rev   <= rev;
            hold_delta <= pos - ref_pos;
            ref_pos    <= pos;
        end
    end

    assert_snap_R6: assert property (@(posedge clk) disable iff (!rst_n)
        trig_rise |=> (hold_pos == $past(pos) && hold_rev == $past(rev)));
    assert_snap_still_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !trig_rise |=> ($stable(hold_pos) && $stable(hold_delta)));
endmodule

// File: rtl/qdec_top.sv
// Incremental encoder decoder top: synchronizes the five encoder-side
// inputs, classifies phase steps, counts position and turns, and captures
// snapshots on trigger.
// Assumes: home_value and err_clr are synchronous to clk.
module qdec_top
    import qdec_pkg::*;
#(
    parameter int POS_W = 32,
    parameter int REV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enc_a,
    input  logic             enc_b,
    input  logic             enc_index,
    input  logic             enc_home,
    input  logic             enc_trig,
    input  logic [POS_W-1:0] home_value,
    input  logic             err_clr,
    output logic [POS_W-1:0] position,
    output logic [REV_W-1:0] rev_count,
    output logic             dir_up,
    output logic             err_illegal,
    output logic [POS_W-1:0] hold_pos,
    output logic [REV_W-1:0] hold_rev,
    output logic [POS_W-1:0] hold_delta
);
    localparam int NEV = 3;

    logic [1:0]     ab_lvl, ab_prv;
    logic [NEV-1:0] ev_lvl, ev_prv, ev_rise;
    step_e          step;

    qdec_sync #(.N(2)) u_sync_ph (
        .clk(clk), .rst_n(rst_n), .d_async({enc_a, enc_b}),
        .lvl(ab_lvl), .prv(ab_prv)
    );

    qdec_sync #(.N(NEV)) u_sync_ev (
        .clk(clk), .rst_n(rst_n), .d_async({enc_trig, enc_home, enc_index}),
        .lvl(ev_lvl), .prv(ev_prv)
    );

    // rising-edge pulses: bit0 index, bit1 home, bit2 trigger
    always_comb ev_rise = ev_lvl & ~ev_prv;

    qdec_step u_step (.ab_now(ab_lvl), .ab_old(ab_prv), .step(step));

    qdec_count #(.POS_W(POS_W), .REV_W(REV_W)) u_count (
        .clk(clk), .rst_n(rst_n), .step(step),
        .index_rise(ev_rise[0]), .home_rise(ev_rise[1]),
        .home_value(home_value), .err_clr(err_clr),
        .pos_q(position), .rev_q(rev_count), .dir_q(dir_up), .err_q(err_illegal)
    );

    qdec_capture #(.POS_W(POS_W), .REV_W(REV_W)) u_cap (
        .clk(clk), .rst_n(rst_n), .trig_rise(ev_rise[2]),
        .pos(position), .rev(rev_count),
        .hold_pos(hold_pos), .hold_rev(hold_rev), .hold_delta(hold_delta)
    );

    assert_home_wins_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_rise[1] && step != STEP_NONE) |=> position == $past(home_value));
    assert_err_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (step == STEP_BAD) |=> err_illegal);
endmodule

// File: tb/qdec_top_test.sv
`timescale 1ns/1ps
module qdec_top_test;
    localparam int POS_W = 32;
    localparam int REV_W = 16;
    localparam int NV = 10;
    // phase states walked in order from {A,B}=00, position 0
    localparam logic [1:0] T_AB [NV] = '{2'b10, 2'b11, 2'b01, 2'b00, 2'b01,
                                         2'b11, 2'b10, 2'b00, 2'b01, 2'b11};
    localparam int T_POS [NV] = '{1, 2, 3, 4, 3, 2, 1, 0, -1, -2};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic enc_a = 1'b0, enc_b = 1'b0, enc_index = 1'b0, enc_home = 1'b0, enc_trig = 1'b0;
    logic [POS_W-1:0] home_value = '0;
    logic err_clr = 1'b0;
    logic [POS_W-1:0] position, hold_pos, hold_delta;
    logic [REV_W-1:0] rev_count, hold_rev;
    logic dir_up, err_illegal;
    int n_run = 0, n_fail = 0;

    always #2.5 clk = ~clk;

    qdec_top #(.POS_W(POS_W), .REV_W(REV_W)) uut (
        .clk(clk), .rst_n(rst_n), .enc_a(enc_a), .enc_b(enc_b),
        .enc_index(enc_index), .enc_home(enc_home), .enc_trig(enc_trig),
        .home_value(home_value), .err_clr(err_clr),
        .position(position), .rev_count(rev_count), .dir_up(dir_up),
        .err_illegal(err_illegal), .hold_pos(hold_pos), .hold_rev(hold_rev),
        .hold_delta(hold_delta)
    );

    task automatic chk(input string tag, input longint act, input longint exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic settle();
        repeat (5) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic phases(input logic [1:0] ab);
        {enc_a, enc_b} = ab;
        settle();
    endtask

    initial begin
        #500000;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R7 reset state
        chk("R7 position", $signed(position), 0);
        chk("R7 rev", $signed(rev_count), 0);
        chk("R7 dir", dir_up, 1);
        chk("R7 err", err_illegal, 0);
        chk("R7 hold", hold_pos | hold_delta | POS_W'(hold_rev), 0);

        // R8 latency: not after two edges, yes after the third
        enc_a = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        chk("R8 early", $signed(position), 0);
        @(posedge clk);
        @(negedge clk);
        chk("R8 third edge", $signed(position), 1);
        phases(2'b00);
        chk("R2 back", $signed(position), 0);
        chk("R2 dir", dir_up, 0);

        // table walk R1 / R2
        for (int i = 0; i < NV; i++) begin
            int prev_exp;
            prev_exp = (i == 0) ? 0 : T_POS[i-1];
            phases(T_AB[i]);
            chk((T_POS[i] > prev_exp) ? "R1 table" : "R2 table", $signed(position), T_POS[i]);
        end
        chk("R2 dir after down", dir_up, 0);

        // R3 illegal 11 -> 00
        phases(2'b00);
        chk("R3 pos held", $signed(position), -2);
        chk("R3 flag", err_illegal, 1);
        chk("R3 dir held", dir_up, 0);
        phases(2'b00);
        chk("R3 sticky", err_illegal, 1);
        err_clr = 1'b1;
        @(negedge clk);
        err_clr = 1'b0;
        @(negedge clk);
        chk("R3 cleared", err_illegal, 0);

        // R4 index while down, R9 held high
        enc_index = 1'b1;
        settle();
        chk("R4 down", $signed(rev_count), -1);
        settle();
        chk("R9 held", $signed(rev_count), -1);
        enc_index = 1'b0;
        settle();
        phases(2'b10);
        chk("R1 step", $signed(position), -1);
        enc_index = 1'b1; settle(); enc_index = 1'b0; settle();
        chk("R4 up", $signed(rev_count), 0);
        enc_index = 1'b1; settle(); enc_index = 1'b0; settle();
        chk("R4 up again", $signed(rev_count), 1);

        // R6 trigger snapshots
        enc_trig = 1'b1; settle(); enc_trig = 1'b0; settle();
        chk("R6 hold_pos", $signed(hold_pos), -1);
        chk("R6 hold_rev", $signed(hold_rev), 1);
        chk("R6 first delta", $signed(hold_delta), -1);
        phases(2'b11);
        phases(2'b01);
        chk("R9 hold stable", $signed(hold_pos), -1);
        enc_trig = 1'b1; settle(); enc_trig = 1'b0; settle();
        chk("R6 hold_pos 2", $signed(hold_pos), 1);
        chk("R6 delta 2", $signed(hold_delta), 2);

        // R5 home reload, and priority over a concurrent step
        home_value = 32'd100;
        enc_home = 1'b1; settle(); enc_home = 1'b0; settle();
        chk("R5 load", $signed(position), 100);
        home_value = 32'd7;
        enc_home = 1'b1;
        {enc_a, enc_b} = 2'b00;
        settle();
        enc_home = 1'b0;
        settle();
        chk("R5 over step", $signed(position), 7);
        chk("R5 step dir", dir_up, 1);

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule